// File: doc/BRIEF.md
# Floating Add/Subtract Operand Aligner

This block is the front half of a single-precision floating adder. It takes two 36-bit floating words and an add/subtract select. For a subtraction it first negates the second operand as a whole word. It then reads each operand's exponent and identifies the operand with the larger exponent. That operand stays in place. The other operand's fraction is shifted right, arithmetically, across a 72-bit field by the difference between the two exponents.

Both aligned operands are scaled down by two bit positions to leave room for carries, and are then added. The block delivers the unnormalized 72-bit sum and a provisional exponent, which a downstream normalizer then processes. Only one operation is in flight at a time. An operand pair is accepted on a valid/ready handshake, and the registered result appears with a one-cycle done pulse.

Top module: `fpa_align_add`

## Requirements
- R1: When `in_sub` is 1, `in_b` is replaced by its 36-bit two's complement before exponent comparison, and the operation proceeds as an addition.
- R2: Word layout: bit 35 is the sign, bits 34:27 the exponent and bits 26:0 the fraction. A negative word carries its exponent ones'-complemented. Its signed fraction is bits 26:0 with bit 35 copied into bits 35:27.
- R3: The operand with the larger exponent is not shifted; its signed fraction occupies bits 71:36 of the 72-bit field, with zeros below. On equal exponents `in_a` is taken as the larger one.
- R4: For an exponent difference d of 0 to 36, the smaller fraction, placed in bits 71:36, is shifted right arithmetically by d.
- R5: For d of 37 to 72, the smaller fraction is moved into the low word, with sign copies in bits 71:36, and is then shifted right arithmetically by d-36.
- R6: For d above 72, the aligned smaller operand is 72 copies of its sign bit.
- R7: `res_sum` = (larger aligned >>> 2) + (smaller aligned >>> 2), computed modulo 2^72. `res_exp` (9 bits) equals the larger exponent plus one.
- R8: A pair is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the following cycle, so `in_valid` is ignored there. `res_done` is high for exactly one cycle, beginning at the second edge after acceptance.
- R9: While `rst_n` is low, `res_done` and both result buses are 0 and `in_ready` is 1.
- R10: `res_sum` and `res_exp` keep their values in every cycle in which `res_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take a pair |
| in_a | input | 36 | First operand (minuend) |
| in_b | input | 36 | Second operand (subtrahend when subtracting) |
| in_sub | input | 1 | 1 = a - b, 0 = a + b |
| res_sum | output | 72 | Unnormalized aligned sum |
| res_exp | output | 9 | Provisional exponent |
| res_done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default 36-bit word, 8-bit exponent and a headroom shift of 2. With an 8-bit exponent, the full difference range up to 255 is reachable. This means every tier edge can be driven directly: 36, 37, 72, 73 and the maximum. Using a maximum exponent of 255 also shows the ninth bit of the provisional exponent being set. Negative operands with large differences confirm that the whole field fills with sign copies.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int WORD_W = 36;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = WORD_W - 1 - EXP_W;
  localparam int DBL_W  = 2 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [EXP_W-1:0]  exp_t;
  typedef logic [DBL_W-1:0]  dbl_t;

  typedef enum logic [1:0] {
    TIER_NEAR = 2'd0,
    TIER_FAR  = 2'd1,
    TIER_GONE = 2'd2
  } tier_e;

  // magnitude exponent: negative words hold it complemented
  function automatic exp_t word_exp(input word_t w);
    return w[WORD_W-1] ? ~w[WORD_W-2 -: EXP_W] : w[WORD_W-2 -: EXP_W];
  endfunction

  // signed fraction with the exponent field replaced by sign copies
  function automatic word_t word_frac(input word_t w);
    return {{(EXP_W+1){w[WORD_W-1]}}, w[FRAC_W-1:0]};
  endfunction

  function automatic tier_e diff_tier(input exp_t d);
    if (d <= exp_t'(WORD_W)) return TIER_NEAR;
    if (d <= exp_t'(DBL_W))  return TIER_FAR;
    return TIER_GONE;
  endfunction

  function automatic dbl_t shift_near(input word_t f, input exp_t d);
    logic signed [DBL_W-1:0] v;
    v = $signed({f, {WORD_W{1'b0}}});
    return dbl_t'(v >>> d);
  endfunction

  function automatic dbl_t shift_far(input word_t f, input exp_t d);
    logic signed [DBL_W-1:0] v;
    exp_t rest;
    v    = $signed({{WORD_W{f[WORD_W-1]}}, f});
    rest = d - exp_t'(WORD_W);
    return dbl_t'(v >>> rest);
  endfunction

  function automatic dbl_t scaled_sum(input dbl_t a, input dbl_t b, input int unsigned h);
    logic signed [DBL_W-1:0] sa;
    logic signed [DBL_W-1:0] sb;
    sa = $signed(a) >>> h;
    sb = $signed(b) >>> h;
    return dbl_t'(sa + sb);
  endfunction
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
  import fpa_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [EXP_W-1:0]  exp_mag,
  output logic [WORD_W-1:0] frac_s
);
  always_comb begin
    exp_mag = word_exp(word);
    frac_s  = word_frac(word);
  end
endmodule

// File: rtl/fpa_order.sv
module fpa_order
  import fpa_pkg::*;
(
  input  logic [EXP_W-1:0]  exp_a,
  input  logic [EXP_W-1:0]  exp_b,
  input  logic [WORD_W-1:0] frac_a,
  input  logic [WORD_W-1:0] frac_b,
  output logic [EXP_W-1:0]  big_exp,
  output logic [WORD_W-1:0] big_frac,
  output logic [WORD_W-1:0] small_frac,
  output logic [EXP_W-1:0]  diff,
  output logic              swapped
);
  always_comb begin
    swapped = exp_b > exp_a;
    if (swapped) begin
      big_exp    = exp_b;
      big_frac   = frac_b;
      small_frac = frac_a;
      diff       = exp_b - exp_a;
    end else begin
      big_exp    = exp_a;
      big_frac   = frac_a;
      small_frac = frac_b;
      diff       = exp_a - exp_b;
    end
  end
endmodule

// File: rtl/fpa_shifter.sv
module fpa_shifter
  import fpa_pkg::*;
(
  input  logic [WORD_W-1:0] frac,
  input  logic [EXP_W-1:0]  diff,
  output logic [1:0]        tier,
  output logic [DBL_W-1:0]  aligned
);
  tier_e t;
  always_comb begin
    t = diff_tier(diff);
    unique case (t)
      TIER_NEAR: aligned = shift_near(frac, diff);
      TIER_FAR:  aligned = shift_far(frac, diff);
      default:   aligned = {DBL_W{frac[WORD_W-1]}};
    endcase
    tier = t;
  end
endmodule

// File: rtl/fpa_align_add.sv
module fpa_align_add
  import fpa_pkg::*;
#(
  parameter int HEAD_SH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_sub,
  output logic [DBL_W-1:0]  res_sum,
  output logic [EXP_W:0]    res_exp,
  output logic              res_done
);
  localparam int NOPS = 2;

  // operand conditioning
  logic [WORD_W-1:0] op_word [NOPS];
  logic [EXP_W-1:0]  op_exp  [NOPS];
  logic [WORD_W-1:0] op_frac [NOPS];

  assign op_word[0] = in_a;
  assign op_word[1] = in_sub ? (~in_b + 1'b1) : in_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_unpack
    fpa_unpack u_unpack (
      .word    (op_word[i]),
      .exp_mag (op_exp[i]),
      .frac_s  (op_frac[i])
    );
  end

  // ordering and alignment (event wires used by the checker)
  logic [EXP_W-1:0]  big_exp;
  logic [WORD_W-1:0] big_frac;
  logic [WORD_W-1:0] small_frac;
  logic [EXP_W-1:0]  ev_diff;
  logic              ev_swapped;
  logic [1:0]        ev_tier;
  logic [DBL_W-1:0]  ev_small_aligned;
  logic              ev_accept;

  fpa_order u_order (
    .exp_a      (op_exp[0]),
    .exp_b      (op_exp[1]),
    .frac_a     (op_frac[0]),
    .frac_b     (op_frac[1]),
    .big_exp    (big_exp),
    .big_frac   (big_frac),
    .small_frac (small_frac),
    .diff       (ev_diff),
    .swapped    (ev_swapped)
  );

  fpa_shifter u_shift (
    .frac    (small_frac),
    .diff    (ev_diff),
    .tier    (ev_tier),
    .aligned (ev_small_aligned)
  );

  // stage 1: aligned operands
  logic             s1_vld;
  logic [DBL_W-1:0] s1_big;
  logic [DBL_W-1:0] s1_small;
  logic [EXP_W:0]   s1_exp;

  assign in_ready  = ~s1_vld;
  assign ev_accept = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_big   <= '0;
      s1_small <= '0;
      s1_exp   <= '0;
    end else begin
      s1_vld <= ev_accept;
      if (ev_accept) begin
        s1_big   <= {big_frac, {WORD_W{1'b0}}};
        s1_small <= ev_small_aligned;
        s1_exp   <= {1'b0, big_exp} + 1'b1;
      end
    end
  end

  // stage 2: scaled sum
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_sum  <= '0;
      res_exp  <= '0;
      res_done <= 1'b0;
    end else begin
      res_done <= s1_vld;
      if (s1_vld) begin
        res_sum <= scaled_sum(s1_big, s1_small, HEAD_SH);
        res_exp <= s1_exp;
      end
    end
  end
endmodule

// File: rtl/fpa_align_add_chk.sv
module fpa_align_add_chk
  import fpa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              in_ready,
  input logic              res_done,
  input logic [DBL_W-1:0]  res_sum,
  input logic [EXP_W:0]    res_exp,
  input logic [1:0]        tier,
  input logic [DBL_W-1:0]  small_aligned,
  input logic [WORD_W-1:0] small_frac
);
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  assert_done_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !res_done ##1 res_done);

  assert_gone_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tier == 2'd2) |-> small_aligned == {DBL_W{small_frac[WORD_W-1]}});

  assert_far_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tier == 2'd1) |->
      small_aligned[DBL_W-1 -: WORD_W] == {WORD_W{small_frac[WORD_W-1]}});

  assert_exp_bumped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> res_exp != '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> ($stable(res_sum) && $stable(res_exp)));
endmodule

bind fpa_align_add fpa_align_add_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .accept        (ev_accept),
  .in_ready      (in_ready),
  .res_done      (res_done),
  .res_sum       (res_sum),
  .res_exp       (res_exp),
  .tier          (ev_tier),
  .small_aligned (ev_small_aligned),
  .small_frac    (small_frac)
);

// File: tb/fpa_align_add_bench.sv
module fpa_align_add_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_a = '0;
  logic [35:0] in_b = '0;
  logic        in_sub = 1'b0;
  logic [71:0] res_sum;
  logic [8:0]  res_exp;
  logic        res_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fpa_align_add u_fpa_align_add (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
    .res_sum(res_sum), .res_exp(res_exp), .res_done(res_done)
  );

  task automatic chk(input string tag, input logic [71:0] got, input logic [71:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // build a word from sign, magnitude exponent and fraction (R2 layout)
  function automatic logic [35:0] mk(input bit neg, input int e, input int f);
    logic [35:0] m;
    m = {1'b0, e[7:0], f[26:0]};
    return neg ? -m : m;
  endfunction

  task automatic split(input logic [35:0] w, output int e, output logic signed [35:0] f);
    logic [35:0] m;
    m = w[35] ? -w : w;
    e = int'(m[34:27]);
    f = $signed({9'b0, m[26:0]});
    if (w[35]) f = -f;
  endtask

  task automatic expect_of(input logic [35:0] a, input logic [35:0] b, input bit sub,
                           output logic [71:0] s, output logic [8:0] x);
    int ea, eb, el, d;
    logic signed [35:0] fa, fb, fl, fs;
    logic signed [399:0] wide;
    logic signed [71:0] big72, small72;
    logic [35:0] bb;
    bb = sub ? -b : b;
    split(a, ea, fa);
    split(bb, eb, fb);
    if (ea >= eb) begin el = ea; fl = fa; fs = fb; d = ea - eb; end
    else          begin el = eb; fl = fb; fs = fa; d = eb - ea; end
    big72   = fl * (72'sd1 <<< 36);
    wide    = fs;
    wide    = wide <<< 300;
    wide    = wide >>> d;
    small72 = wide[335:264];
    s = (big72 >>> 2) + (small72 >>> 2);
    x = 9'(el + 1);
  endtask

  task automatic run_op(input string tag, input logic [35:0] a, input logic [35:0] b,
                        input bit sub, input bit junk_when_busy);
    logic [71:0] es;
    logic [8:0]  ex;
    expect_of(a, b, sub, es, ex);
    @(negedge clk);
    chk({tag, " R8 ready"}, 72'(in_ready), 72'd1);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    chk({tag, " R8 busy"}, 72'(in_ready), 72'd0);
    chk({tag, " R8 early"}, 72'(res_done), 72'd0);
    if (junk_when_busy) begin
      in_a = ~a; in_b = 36'h1; in_sub = ~sub;
    end else in_valid = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R8 done"}, 72'(res_done), 72'd1);
    chk({tag, " R7 sum"}, res_sum, es);
    chk({tag, " R7 exp"}, 72'(res_exp), 72'(ex));
    @(negedge clk);
    chk({tag, " R8 pulse"}, 72'(res_done), 72'd0);
    chk({tag, " R10 hold"}, res_sum, es);
  endtask

  task automatic t_reset;
    chk("R9 done", 72'(res_done), 72'd0);
    chk("R9 sum", res_sum, 72'd0);
    chk("R9 exp", 72'(res_exp), 72'd0);
    chk("R9 ready", 72'(in_ready), 72'd1);
  endtask

  task automatic t_equal;    run_op("R3 R4 equal exp", mk(0,128,27'h4000000), mk(0,128,27'h2000000), 0, 0); endtask
  task automatic t_swap;     run_op("R3 b larger", mk(0,130,27'h5555555), mk(0,140,27'h4000001), 0, 0); endtask
  task automatic t_near36;   run_op("R4 d36", mk(1,100,27'h7000003), mk(0,136,27'h4000000), 0, 0); endtask
  task automatic t_far37;    run_op("R5 d37", mk(0,137,27'h4000000), mk(1,100,27'h6abcdef), 0, 0); endtask
  task automatic t_far72;    run_op("R5 d72", mk(0,172,27'h4000000), mk(1,100,27'h7ffffff), 0, 0); endtask
  task automatic t_gone73;   run_op("R6 d73", mk(0,173,27'h4000000), mk(1,100,27'h4000001), 0, 0); endtask
  task automatic t_gone_max; run_op("R6 d254", mk(1,255,27'h4000000), mk(1,1,27'h5000000), 0, 0); endtask
  task automatic t_sub;      run_op("R1 sub", mk(0,129,27'h6000000), mk(0,128,27'h4000000), 1, 0); endtask
  task automatic t_sub_neg;  run_op("R1 sub neg", mk(1,120,27'h4321000), mk(1,110,27'h7777777), 1, 0); endtask
  task automatic t_neg_exp;  run_op("R2 neg exp", mk(1,200,27'h4000000), mk(0,60,27'h4000000), 0, 0); endtask
  task automatic t_busy;     run_op("R8 ignore busy", mk(0,90,27'h4800000), mk(0,80,27'h4000000), 0, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_equal();
    t_swap();
    t_near36();
    t_far37();
    t_far72();
    t_gone73();
    t_gone_max();
    t_sub();
    t_sub_neg();
    t_neg_exp();
    t_busy();
    @(negedge clk);
    chk("R8 no second done", 72'(res_done), 72'd0);
    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule